// File: doc/BRIEF.md
# Parallel Slave Port Controller

This block lets an external bus master exchange 8-bit words with an on-chip CPU through a pair of single-word mailboxes. The master writes into the inbound buffer and reads from the outbound buffer. It uses an active-low chip select, an active-low read strobe and an active-low write strobe, none of which are tied to the CPU clock. The CPU reaches the same two buffers through one data address. It reaches the combined control and status register through a second address.

The strobes pass through two-flop synchronisers into the CPU clock domain. A flag update happens on the rising (trailing) edge of a strobe that arrives while chip select is low. The control/status register holds several things: the inbound-full flag, the outbound-full flag, a sticky overflow flag, the port-enable mode bit, and the direction bits of three neighbouring general-purpose pins. When the mode bit is clear the block behaves as plain I/O: the master's strobes do nothing, the buffer flags hold, and the external bus is never driven.

Top module: `pport_ctrl`

## Requirements
- R1: After reset the control/status register (cpu_addr=1) reads 0x07, pin_dir is 3'b111, and ext_data_oe is 0.
- R2: With the mode bit set, a master write stores the word and sets bit 7 (inbound full). A CPU read of the data address (cpu_addr=0) returns that word and clears bit 7.
- R3: With the mode bit set, a CPU write to the data address sets bit 6 (outbound full). A master read then sees that word on ext_data_out and clears bit 6.
- R4: A master write that completes while bit 7 is already 1 sets bit 5 (overflow), and the newer word replaces the buffered one. Bit 5 stays 1 until the CPU writes the control register with bit 5 at 0.
- R5: With the mode bit (bit 4) at 0, master strobes are ignored. Bits 7 and 6 and the inbound word do not change, including through CPU data accesses. A CPU data write still updates the outbound word.
- R6: ext_data_oe is 1 only while ext_cs_n and ext_rd_n are both low and the mode bit is 1.
- R7: In the control register, bit 3 always reads 0, and bits 7 and 6 ignore CPU writes. Bits 5, 4 and 2..0 take the written value. Bits 2..0 appear on pin_dir, where 1 means input.
- R8: A CPU data read that falls in the same cycle as a completing master write leaves bit 7 at 1 and does not set bit 5.
- R9: Flags change on the trailing (rising) edge of a strobe, not on its falling edge. With two synchroniser stages, the change appears within three clock edges of that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| ext_cs_n | input | 1 | Master chip select, active low, asynchronous |
| ext_rd_n | input | 1 | Master read strobe, active low, asynchronous |
| ext_wr_n | input | 1 | Master write strobe, active low, asynchronous |
| ext_data_in | input | 8 | Data from master |
| ext_data_out | output | 8 | Data to master (outbound word) |
| ext_data_oe | output | 1 | Output enable for the external bus; 0 means high impedance |
| cpu_addr | input | 1 | 0 selects the data buffer, 1 the control/status register |
| cpu_wr | input | 1 | CPU write strobe, one clock |
| cpu_rd | input | 1 | CPU read strobe, one clock; data reads have side effects |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from address |
| pin_dir | output | 3 | Direction of the three shared pins, 1 = input |

## Verification
The bench goes after the overflow path. It writes twice without a CPU read between, which catches a flag that is not sticky, or one that clears itself on the next good write. It times a CPU data read into the exact clock where a master write completes: a design that lets the clear win would lose the new word, and one that counts that write as an overflow would raise a false error. It switches the mode bit off and strobes the port, so a design that still moves flags or drives the bus shows up at once. It also samples bit 7 while the write strobe is still low, which exposes an update on the wrong edge.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int DATA_W = 8;
    localparam int DIR_W  = 3;

    // control/status field positions (software-visible layout)
    localparam int BIT_IBF  = 7;
    localparam int BIT_OBF  = 6;
    localparam int BIT_OVF  = 5;
    localparam int BIT_MODE = 4;
    localparam int BIT_RSVD = 3;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    // indices into the synchroniser vector
    localparam int SIG_CS = 0;
    localparam int SIG_RD = 1;
    localparam int SIG_WR = 2;
    localparam int SIG_N  = 3;

    typedef struct packed {
        logic              ibf;
        logic              obf;
        logic              ovf;
        logic              mode;
        logic [DIR_W-1:0]  dir;
        logic [DATA_W-1:0] in_buf;
        logic [DATA_W-1:0] out_buf;
        logic [DATA_W-1:0] hold;
    } port_state_t;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] IDLE   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] chain_d [DEPTH];
    logic [W-1:0] chain_q [DEPTH];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= IDLE;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/pport_core.sv
module pport_core
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              wr_lvl,
    input  logic              wr_rise,
    input  logic              rd_rise,
    input  logic [DATA_W-1:0] ext_din,
    input  logic              cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output port_state_t       st_o
);
    port_state_t st_d, st_q;

    logic rd_dat, wr_dat, wr_ctl, ext_wr_ev, ext_rd_ev;

    always_comb begin
        rd_dat    = cpu_rd && (cpu_addr == ADDR_DATA);
        wr_dat    = cpu_wr && (cpu_addr == ADDR_DATA);
        wr_ctl    = cpu_wr && (cpu_addr == ADDR_CTRL);
        ext_wr_ev = st_q.mode && wr_rise;
        ext_rd_ev = st_q.mode && rd_rise;

        st_d = st_q;

        // track master data while its write strobe is held inside the select
        if (st_q.mode && !cs_lvl && !wr_lvl) st_d.hold = ext_din;

        if (wr_dat) st_d.out_buf = cpu_wdata;

        if (wr_ctl) begin
            st_d.ovf  = cpu_wdata[BIT_OVF];
            st_d.mode = cpu_wdata[BIT_MODE];
            st_d.dir  = cpu_wdata[DIR_W-1:0];
        end

        if (st_q.mode) begin
            if (rd_dat)    st_d.ibf = 1'b0;
            if (ext_rd_ev) st_d.obf = 1'b0;
            if (wr_dat)    st_d.obf = 1'b1;   // a fresh word outranks a drain
            if (ext_wr_ev) begin
                if (st_q.ibf && !rd_dat) st_d.ovf = 1'b1;
                st_d.ibf    = 1'b1;           // arriving word outranks the clear
                st_d.in_buf = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.dir     <= '1;
        end else begin
            st_q         <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_cs_n,
    input  logic              ext_rd_n,
    input  logic              ext_wr_n,
    input  logic [DATA_W-1:0] ext_data_in,
    output logic [DATA_W-1:0] ext_data_out,
    output logic              ext_data_oe,
    input  logic              cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DIR_W-1:0]  pin_dir
);
    logic [SIG_N-1:0] raw, sync_v, prev_v;
    logic             wr_rise, rd_rise;
    port_state_t      st;
    logic             st_ibf, st_obf, st_ovf, st_mode;

    assign raw[SIG_CS] = ext_cs_n;
    assign raw[SIG_RD] = ext_rd_n;
    assign raw[SIG_WR] = ext_wr_n;

    pport_sync #(.W(SIG_N), .STAGES(SYNC_STAGES), .IDLE('1)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (sync_v),
        .prev_o  (prev_v)
    );

    assign wr_rise = sync_v[SIG_WR] && !prev_v[SIG_WR] && !sync_v[SIG_CS];
    assign rd_rise = sync_v[SIG_RD] && !prev_v[SIG_RD] && !sync_v[SIG_CS];

    pport_core core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (sync_v[SIG_CS]),
        .wr_lvl    (sync_v[SIG_WR]),
        .wr_rise   (wr_rise),
        .rd_rise   (rd_rise),
        .ext_din   (ext_data_in),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_wdata (cpu_wdata),
        .st_o      (st)
    );

    assign st_ibf  = st.ibf;
    assign st_obf  = st.obf;
    assign st_ovf  = st.ovf;
    assign st_mode = st.mode;

    always_comb begin
        if (cpu_addr == ADDR_DATA) begin
            cpu_rdata = st.in_buf;
        end else begin
            cpu_rdata                = '0;
            cpu_rdata[BIT_IBF]       = st.ibf;
            cpu_rdata[BIT_OBF]       = st.obf;
            cpu_rdata[BIT_OVF]       = st.ovf;
            cpu_rdata[BIT_MODE]      = st.mode;
            cpu_rdata[DIR_W-1:0]     = st.dir;
        end
    end

    assign ext_data_out = st.out_buf;
    assign ext_data_oe  = st.mode && !ext_cs_n && !ext_rd_n;
    assign pin_dir      = st.dir;

endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_addr,
    input logic cpu_wr,
    input logic cpu_rd,
    input logic ext_data_oe,
    input logic st_ibf,
    input logic st_obf,
    input logic st_ovf,
    input logic st_mode
);
    // R6
    oe_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mode |-> !ext_data_oe);

    // R5
    flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mode |=> ($stable(st_ibf) && $stable(st_obf)));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovf && !(cpu_wr && cpu_addr)) |=> st_ovf);

    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovf) |-> ($past(st_ibf) || $past(cpu_wr && cpu_addr)));

    // R3
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr && st_mode) |=> st_obf);

    // R2
    ibf_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ibf) |-> $past(st_mode));

endmodule

bind pport_ctrl pport_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .ext_data_oe (ext_data_oe),
    .st_ibf      (st_ibf),
    .st_obf      (st_obf),
    .st_ovf      (st_ovf),
    .st_mode     (st_mode)
);

// File: tb/pport_ctrl_tb.sv
module pport_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] ext_data_in = '0;
    logic [7:0] ext_data_out;
    logic       ext_data_oe;
    logic       cpu_addr = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [2:0] pin_dir;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model
    bit       m_ibf, m_obf, m_ovf, m_mode;
    bit [2:0] m_dir;
    bit [7:0] m_in, m_out;

    always #4 clk = ~clk;   // 125 MHz

    pport_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_data_in(ext_data_in), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_dir(pin_dir)
    );

    function automatic bit [7:0] exp_ctrl();
        return {m_ibf, m_obf, m_ovf, m_mode, 1'b0, m_dir};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a) begin
            m_ovf = v[5]; m_mode = v[4]; m_dir = v[2:0];
        end else begin
            m_out = v;
            if (m_mode) m_obf = 1'b1;
        end
    endtask

    task automatic cpu_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
        if (!a && m_mode) m_ibf = 1'b0;
    endtask

    task automatic check_ctrl(input string tag);
        logic [7:0] v;
        cpu_read(1'b1, v);
        chk(v, exp_ctrl(), tag);
        chk({5'd0, pin_dir}, {5'd0, m_dir}, "R7 pin_dir");
    endtask

    task automatic ext_write(input logic [7:0] v);
        @(negedge clk);
        ext_cs_n = 1'b0; ext_data_in = v;
        tick(2);
        ext_wr_n = 1'b0;
        tick(4);
        ext_wr_n = 1'b1;
        tick(4);
        ext_cs_n = 1'b1;
        tick(2);
        if (m_mode) begin
            if (m_ibf) m_ovf = 1'b1;
            m_ibf = 1'b1;
            m_in  = v;
        end
    endtask

    task automatic ext_read();
        @(negedge clk);
        ext_cs_n = 1'b0;
        tick(1);
        chk({7'd0, ext_data_oe}, 8'd0, "R6 oe with cs only");
        tick(1);
        ext_rd_n = 1'b0;
        #1;
        chk({7'd0, ext_data_oe}, {7'd0, m_mode}, "R6 oe during read");
        if (m_mode) chk(ext_data_out, m_out, "R3 outbound word");
        tick(4);
        ext_rd_n = 1'b1;
        #1 chk({7'd0, ext_data_oe}, 8'd0, "R6 oe after read");
        tick(4);
        ext_cs_n = 1'b1;
        tick(2);
        if (m_mode) m_obf = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int unsigned r;
        r = $urandom(32'h1d2c3b4a);
        m_ibf = 0; m_obf = 0; m_ovf = 0; m_mode = 0; m_dir = 3'b111; m_in = 0; m_out = 0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk({7'd0, ext_data_oe}, 8'd0, "R1 oe at reset");
        check_ctrl("R1 ctrl at reset");

        // R5 port disabled: strobes ignored
        ext_write(8'hA5);
        check_ctrl("R5 write ignored");
        cpu_write(1'b0, 8'h3C);
        check_ctrl("R5 data write keeps flags");
        ext_read();
        cpu_read(1'b0, v);
        chk(v, 8'h00, "R5 inbound word unchanged");

        // R7 read-only and reserved bits
        cpu_write(1'b1, 8'hDA);  // tries bits 7,6,3; sets mode, dir=010
        check_ctrl("R7 ctrl layout");

        // R9 no update while strobe low, then R2
        @(negedge clk);
        ext_cs_n = 1'b0; ext_data_in = 8'h5E;
        tick(2);
        ext_wr_n = 1'b0;
        tick(5);
        cpu_addr = 1'b1; #1;
        chk(cpu_rdata[7:0] & 8'h80, 8'h00, "R9 no flag on falling edge");
        ext_wr_n = 1'b1;
        tick(3);
        #1 chk(cpu_rdata & 8'h80, 8'h80, "R9 flag within three edges");
        tick(1);
        ext_cs_n = 1'b1;
        m_ibf = 1; m_in = 8'h5E;
        check_ctrl("R2 inbound full");
        cpu_read(1'b0, v);
        chk(v, 8'h5E, "R2 inbound word");
        check_ctrl("R2 full cleared");

        // R3
        cpu_write(1'b0, 8'hC3);
        check_ctrl("R3 outbound full");
        ext_read();
        check_ctrl("R3 outbound drained");

        // R4 overflow, newest word kept, sticky
        ext_write(8'h11);
        ext_write(8'h22);
        check_ctrl("R4 overflow set");
        cpu_read(1'b0, v);
        chk(v, 8'h22, "R4 newest word kept");
        ext_write(8'h33);
        check_ctrl("R4 overflow sticky");
        cpu_read(1'b0, v);
        cpu_write(1'b1, {3'b000, 1'b1, 1'b0, m_dir});
        check_ctrl("R4 overflow cleared by zero write");

        // R8 CPU read in the completion cycle of a master write, buffer already full
        ext_write(8'h44);
        @(negedge clk);
        ext_cs_n = 1'b0; ext_data_in = 8'h55;
        tick(2);
        ext_wr_n = 1'b0;
        tick(4);
        ext_wr_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        cpu_addr = 1'b0; cpu_rd = 1'b1;
        #1 chk(cpu_rdata, 8'h44, "R8 old word read");
        @(negedge clk);
        cpu_rd = 1'b0;
        tick(2);
        ext_cs_n = 1'b1;
        m_ibf = 1; m_in = 8'h55;
        check_ctrl("R8 full kept, no overflow");
        cpu_read(1'b0, v);
        chk(v, 8'h55, "R8 new word kept");

        // random mix
        for (int i = 0; i < 150; i++) begin
            r = $urandom;
            case (r % 6)
                0: ext_write(8'($urandom));
                1: ext_read();
                2: begin
                    logic [7:0] e;
                    e = m_in;
                    cpu_read(1'b0, v);
                    chk(v, e, "R2 random inbound");
                end
                3: cpu_write(1'b0, 8'($urandom));
                4: begin
                    logic [7:0] w;
                    w = 8'($urandom);
                    w[4] = (($urandom % 8) != 0);
                    if (($urandom % 2) == 0) w[5] = 1'b0;
                    cpu_write(1'b1, w);
                end
                default: ;
            endcase
            check_ctrl("R7 random ctrl");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule